// File: doc/BRIEF.md
# Asynchronous SRAM Write-Timing Monitor

This block watches the control, address and data pins of an asynchronous static RAM and checks every write cycle against a set of minimum timing limits. A fast clock samples the pins, so all limits are given as counts of samples ("ticks"), each rounded up from the nanosecond figure of the memory grade in use. The block is passive. It drives nothing toward the memory. It raises one sticky flag for each kind of timing breach and counts the writes it has seen.

A write is in progress only while three things hold at once: chip enable is low, write enable is low, and at least one byte strobe is low. The write ends at the first sample where any of the three stops holding. All checks that refer to the end of a write are taken at that closing sample, whichever signal caused it. Each check measures a run of consecutive samples that ends at the last active sample. An integration bench or a board-level test harness connects the block beside a memory model or a memory controller. Software-free firmware checks can also read its flags after a test sequence.

Top module: `sram_write_monitor`

## Requirements
- R1: A sample is write-active when `ce_n`=0, `we_n`=0, and `lb_n`=0 or `ub_n`=0. Either strobe alone is enough. If one strobe rises while the other stays low, the write does not end.
- R2: A write closes at the first sample that is not write-active after one that was. It does not matter whether `we_n`, `ce_n` or the strobes caused the close. The same end-of-write checks apply in every case, and they measure runs of samples that end at the last active sample.
- R3: `wr_count` rises by exactly one for each closed write and holds its value otherwise.
- R4: `viol[0]` is set when, at close, `ce_n` has been low for fewer than `T_CE_END` consecutive samples.
- R5: `viol[1]` is set when, at close, the address has been unchanged for fewer than `T_ADDR_SU` consecutive samples.
- R6: `viol[2]` is set when, at close, the data has been unchanged for fewer than `T_DATA_SU` consecutive samples.
- R7: `viol[3]` is set when, at close, `we_n` has been low for fewer than `T_WE_PW` consecutive samples.
- R8: `viol[4]` is set when, at close, at least one strobe has been low for fewer than `T_STB_PW` consecutive samples.
- R9: `viol[5]` is set when a write opens fewer than `T_CYCLE` samples after the previous write opened. The first write after reset is never flagged.
- R10: `viol[6]` is set when the address differs between two consecutive write-active samples.
- R11: `viol[7]` is set when the address differs from the last active sample's address in any of the `T_ADDR_HOLD` samples that start with the closing sample. When `T_ADDR_HOLD` is 0, this check is off.
- R12: Once set, a flag stays set until `clr` is high for a clock. That clock clears every flag that is not newly raised in the same cycle.
- R13: After reset, all flags read 0 and `wr_count` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all violation flags |
| ce_n | input | 1 | Sampled chip enable, active low |
| we_n | input | 1 | Sampled write enable, active low |
| lb_n | input | 1 | Sampled low-byte strobe, active low |
| ub_n | input | 1 | Sampled high-byte strobe, active low |
| addr | input | ADDR_W | Sampled address bus |
| data | input | DATA_W | Sampled data bus |
| viol | output | 8 | Sticky violation flags, bit positions as in R4 to R11 |
| wr_count | output | CNT_W | Number of closed writes |

## Verification
The assertions assume that the pins are already synchronous to `clk`. In particular, each value is present for whole sample periods, so the sample register never captures a value in the middle of a change. The bench meets this assumption by changing every input only on the falling clock edge and holding it for at least one full period. The clear check is conditioned on no new breach arriving in the same cycle. The bench pulses `clr` only while the memory pins are idle.

// File: rtl/smon_pkg.sv
package smon_pkg;

    localparam int NUM_RULES = 8;

    typedef enum int unsigned {
        RULE_CE_END    = 0,
        RULE_ADDR_SU   = 1,
        RULE_DATA_SU   = 2,
        RULE_WE_PW     = 3,
        RULE_STB_PW    = 4,
        RULE_CYCLE     = 5,
        RULE_ADDR_MOVE = 6,
        RULE_ADDR_HOLD = 7
    } rule_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic lb_n;
        logic ub_n;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{ce_n: 1'b1, we_n: 1'b1, lb_n: 1'b1, ub_n: 1'b1};

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/smon_run_counter.sv
// Saturating run-length counter: restart loads 1, keep extends, otherwise 0.
module smon_run_counter #(
    parameter int RUN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             keep,
    input  logic             restart,
    output logic [RUN_W-1:0] run
);
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    typedef struct packed {
        logic [RUN_W-1:0] run;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.run = RUN_W'(1);
        end else if (keep) begin
            if (st_q.run != RUN_MAX) begin
                st_d.run = st_q.run + RUN_W'(1);
            end
        end else begin
            st_d.run = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run = st_q.run;

endmodule

// File: rtl/smon_change_tracker.sv
// Flags a change from the previous sample and counts samples since the last change.
module smon_change_tracker #(
    parameter int VAL_W = 16,
    parameter int RUN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VAL_W-1:0] val,
    output logic             changed,
    output logic [RUN_W-1:0] run
);
    typedef struct packed {
        logic [VAL_W-1:0] prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = val;
        changed   = (val != st_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    smon_run_counter #(.RUN_W(RUN_W)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .keep    (1'b1),
        .restart (changed),
        .run     (run)
    );

endmodule

// File: rtl/smon_window.sv
// Tracks the three-way overlap that forms the internal write window.
module smon_window
    import smon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  ctl_t ctl,
    output logic active,
    output logic opened,
    output logic closed
);
    typedef struct packed {
        logic was_active;
    } st_t;

    st_t  st_d, st_q;
    logic any_strobe;

    always_comb begin
        any_strobe      = ~ctl.lb_n | ~ctl.ub_n;
        active          = ~ctl.ce_n & ~ctl.we_n & any_strobe;
        opened          = active & ~st_q.was_active;
        closed          = ~active & st_q.was_active;
        st_d            = st_q;
        st_d.was_active = active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/smon_rules.sv
// Evaluates every timing rule, keeps sticky flags and the write counter.
module smon_rules
    import smon_pkg::*;
#(
    parameter int RUN_W       = 4,
    parameter int CNT_W       = 16,
    parameter int T_CE_END    = 4,
    parameter int T_ADDR_SU   = 5,
    parameter int T_DATA_SU   = 3,
    parameter int T_WE_PW     = 4,
    parameter int T_STB_PW    = 5,
    parameter int T_CYCLE     = 6,
    parameter int T_ADDR_HOLD = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 active,
    input  logic                 opened,
    input  logic                 closed,
    input  logic [RUN_W-1:0]     ce_run,
    input  logic [RUN_W-1:0]     we_run,
    input  logic [RUN_W-1:0]     stb_run,
    input  logic [RUN_W-1:0]     addr_run,
    input  logic [RUN_W-1:0]     data_run,
    input  logic                 addr_changed,
    output logic [NUM_RULES-1:0] new_viol,
    output logic [NUM_RULES-1:0] viol,
    output logic [CNT_W-1:0]     wr_count
);
    localparam int               HOLD_W    = (T_ADDR_HOLD > 1) ? $clog2(T_ADDR_HOLD) : 1;
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'((T_ADDR_HOLD > 0) ? T_ADDR_HOLD - 1 : 0);
    localparam logic [RUN_W-1:0]  CYC_MAX   = '1;

    typedef struct packed {
        logic [NUM_RULES-1:0] viol;
        logic [CNT_W-1:0]     count;
        logic [RUN_W-1:0]     cyc;
        logic                 seen;
        logic [HOLD_W-1:0]    hold;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        new_viol = '0;

        if (closed) begin
            new_viol[RULE_CE_END]  = int'(ce_run)   < T_CE_END;
            new_viol[RULE_ADDR_SU] = int'(addr_run) < T_ADDR_SU;
            new_viol[RULE_DATA_SU] = int'(data_run) < T_DATA_SU;
            new_viol[RULE_WE_PW]   = int'(we_run)   < T_WE_PW;
            new_viol[RULE_STB_PW]  = int'(stb_run)  < T_STB_PW;
            if (T_ADDR_HOLD > 0) begin
                new_viol[RULE_ADDR_HOLD] = addr_changed;
            end
        end else if (st_q.hold != '0) begin
            new_viol[RULE_ADDR_HOLD] = addr_changed;
        end

        if (opened && st_q.seen) begin
            new_viol[RULE_CYCLE] = int'(st_q.cyc) < T_CYCLE;
        end

        if (active && !opened) begin
            new_viol[RULE_ADDR_MOVE] = addr_changed;
        end

        st_d      = st_q;
        st_d.viol = (clr ? '0 : st_q.viol) | new_viol;

        if (closed) begin
            st_d.count = st_q.count + CNT_W'(1);
        end

        if (opened) begin
            st_d.cyc  = RUN_W'(1);
            st_d.seen = 1'b1;
        end else if (st_q.cyc != CYC_MAX) begin
            st_d.cyc = st_q.cyc + RUN_W'(1);
        end

        if (closed) begin
            st_d.hold = HOLD_LOAD;
        end else if (st_q.hold != '0) begin
            st_d.hold = st_q.hold - HOLD_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign viol     = st_q.viol;
    assign wr_count = st_q.count;

endmodule

// File: rtl/sram_write_monitor.sv
module sram_write_monitor
    import smon_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int CNT_W       = 16,
    parameter int T_CE_END    = 4,
    parameter int T_ADDR_SU   = 5,
    parameter int T_DATA_SU   = 3,
    parameter int T_WE_PW     = 4,
    parameter int T_STB_PW    = 5,
    parameter int T_CYCLE     = 6,
    parameter int T_ADDR_HOLD = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 ce_n,
    input  logic                 we_n,
    input  logic                 lb_n,
    input  logic                 ub_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    data,
    output logic [NUM_RULES-1:0] viol,
    output logic [CNT_W-1:0]     wr_count
);
    localparam int T_MAX = max_of(max_of(max_of(T_CE_END, T_ADDR_SU), max_of(T_DATA_SU, T_WE_PW)),
                                  max_of(T_STB_PW, T_CYCLE));
    localparam int RUN_W   = $clog2(T_MAX + 2);
    localparam int NUM_LVL = 3;
    localparam int LVL_CE  = 0;
    localparam int LVL_WE  = 1;
    localparam int LVL_STB = 2;

    typedef struct packed {
        ctl_t              ctl;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } samp_t;

    samp_t samp_d, samp_q;

    always_comb begin
        samp_d      = samp_q;
        samp_d.ctl  = '{ce_n: ce_n, we_n: we_n, lb_n: lb_n, ub_n: ub_n};
        samp_d.addr = addr;
        samp_d.data = data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= '{ctl: CTL_IDLE, addr: '0, data: '0};
        end else begin
            samp_q <= samp_d;
        end
    end

    logic win_now, win_open, win_close;

    smon_window u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl    (samp_q.ctl),
        .active (win_now),
        .opened (win_open),
        .closed (win_close)
    );

    logic [NUM_LVL-1:0] lvl_cond;
    logic [RUN_W-1:0]   lvl_run [NUM_LVL];

    always_comb begin
        lvl_cond          = '0;
        lvl_cond[LVL_CE]  = ~samp_q.ctl.ce_n;
        lvl_cond[LVL_WE]  = ~samp_q.ctl.we_n;
        lvl_cond[LVL_STB] = ~samp_q.ctl.lb_n | ~samp_q.ctl.ub_n;
    end

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        smon_run_counter #(.RUN_W(RUN_W)) u_lvl (
            .clk     (clk),
            .rst_n   (rst_n),
            .keep    (lvl_cond[g]),
            .restart (1'b0),
            .run     (lvl_run[g])
        );
    end

    logic             addr_changed, data_changed;
    logic [RUN_W-1:0] addr_run, data_run;

    smon_change_tracker #(.VAL_W(ADDR_W), .RUN_W(RUN_W)) u_addr_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .val     (samp_q.addr),
        .changed (addr_changed),
        .run     (addr_run)
    );

    smon_change_tracker #(.VAL_W(DATA_W), .RUN_W(RUN_W)) u_data_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .val     (samp_q.data),
        .changed (data_changed),
        .run     (data_run)
    );

    logic                 data_moved_in_window;
    logic [NUM_RULES-1:0] new_viol;

    // Data may legally move inside the window; only its run length matters.
    assign data_moved_in_window = data_changed & win_now;

    smon_rules #(
        .RUN_W       (RUN_W),
        .CNT_W       (CNT_W),
        .T_CE_END    (T_CE_END),
        .T_ADDR_SU   (T_ADDR_SU),
        .T_DATA_SU   (T_DATA_SU),
        .T_WE_PW     (T_WE_PW),
        .T_STB_PW    (T_STB_PW),
        .T_CYCLE     (T_CYCLE),
        .T_ADDR_HOLD (T_ADDR_HOLD)
    ) u_rules (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (clr),
        .active       (win_now),
        .opened       (win_open),
        .closed       (win_close),
        .ce_run       (lvl_run[LVL_CE]),
        .we_run       (lvl_run[LVL_WE]),
        .stb_run      (lvl_run[LVL_STB]),
        .addr_run     (addr_run),
        .data_run     (data_run),
        .addr_changed (addr_changed),
        .new_viol     (new_viol),
        .viol         (viol),
        .wr_count     (wr_count)
    );

endmodule

// File: rtl/smon_checker.sv
module smon_checker #(
    parameter int NUM   = 8,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             win,
    input logic             close,
    input logic             dmove,
    input logic [NUM-1:0]   viol,
    input logic [NUM-1:0]   new_viol,
    input logic [CNT_W-1:0] wr_count
);

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        close |=> (wr_count == $past(wr_count) + CNT_W'(1)));

    assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !close |=> $stable(wr_count));

    assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((viol & $past(viol)) == $past(viol)));

    assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (new_viol == '0)) |=> (viol == '0));

    assert_move_in_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol[6]) |-> $past(win));

    assert_setup_at_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol[2]) |-> $past(close));

    assert_spacing_at_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol[5]) |-> $past(win));

    assert_data_move_no_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dmove && !close && !clr) |=> (viol[2] == $past(viol[2])));

endmodule

bind sram_write_monitor smon_checker #(
    .NUM   (smon_pkg::NUM_RULES),
    .CNT_W (CNT_W)
) u_smon_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .win      (win_now),
    .close    (win_close),
    .dmove    (data_moved_in_window),
    .viol     (viol),
    .new_viol (new_viol),
    .wr_count (wr_count)
);

// File: tb/tb_sram_write_monitor.sv
module tb_sram_write_monitor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
    logic [15:0] addr = '0;
    logic [15:0] data = '0;
    logic [7:0]  viol;
    logic [15:0] wr_count;

    int total = 0;
    int bad = 0;
    int exp_count = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sram_write_monitor dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .lb_n     (lb_n),
        .ub_n     (ub_n),
        .addr     (addr),
        .data     (data),
        .viol     (viol),
        .wr_count (wr_count)
    );

    // Limits used: CE 4, addr setup 5, data setup 3, WE 4, strobe 5, cycle 6, addr hold 1.
    typedef struct packed {
        logic [3:0] lead;   // samples with CE low before WE falls
        logic [3:0] slead;  // of those, samples with strobes low
        logic [3:0] wlen;   // active samples
        logic [3:0] dlead;  // samples new data is present before close
        logic [1:0] endsel; // 0: WE rises, 1: CE rises, 2: strobes rise
        logic [1:0] smask;  // bit0 low strobe, bit1 high strobe
        logic       achg;   // address moves on second active sample
        logic       hchg;   // address moves on closing sample
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{4'd3, 4'd3, 4'd4, 4'd3, 2'd0, 2'b11, 1'b0, 1'b0, 8'h00},
        '{4'd1, 4'd1, 4'd2, 4'd1, 2'd0, 2'b01, 1'b0, 1'b0, 8'h1F},
        '{4'd2, 4'd0, 4'd4, 4'd4, 2'd1, 2'b10, 1'b0, 1'b0, 8'h10},
        '{4'd3, 4'd2, 4'd4, 4'd2, 2'd2, 2'b11, 1'b0, 1'b0, 8'h04},
        '{4'd3, 4'd3, 4'd5, 4'd3, 2'd0, 2'b11, 1'b1, 1'b0, 8'h42},
        '{4'd3, 4'd3, 4'd4, 4'd3, 2'd1, 2'b01, 1'b0, 1'b1, 8'h80},
        '{4'd1, 4'd1, 4'd3, 4'd3, 2'd2, 2'b10, 1'b0, 1'b0, 8'h1A},
        '{4'd4, 4'd1, 4'd6, 4'd2, 2'd0, 2'b11, 1'b1, 1'b1, 8'hC4}
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic go_idle(input int n);
        ce_n = 1'b1; we_n = 1'b1; lb_n = 1'b1; ub_n = 1'b1;
        repeat (n) step();
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        step();
        clr = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        logic [15:0] a;
        logic [15:0] d;
        a = 16'h0100 + 16'(idx * 4);
        d = 16'h1111 * 16'(idx + 1);
        pulse_clr();
        for (int i = 0; i < int'(v.lead); i++) begin
            ce_n = 1'b0;
            addr = a;
            if (i >= int'(v.lead) - int'(v.slead)) begin
                lb_n = ~v.smask[0];
                ub_n = ~v.smask[1];
            end
            step();
        end
        for (int j = 0; j < int'(v.wlen); j++) begin
            we_n = 1'b0;
            lb_n = ~v.smask[0];
            ub_n = ~v.smask[1];
            if (v.achg && j >= 1) addr = a ^ 16'h0001;
            if (j >= int'(v.wlen) - int'(v.dlead)) data = d;
            step();
        end
        case (v.endsel)
            2'd0:    we_n = 1'b1;
            2'd1:    ce_n = 1'b1;
            default: begin lb_n = 1'b1; ub_n = 1'b1; end
        endcase
        if (v.hchg) addr = addr ^ 16'h0002;
        step();
        go_idle(9);
        exp_count++;
        check(viol == v.exp, $sformatf("R1/R2/R4/R5/R6/R7/R8/R10/R11 vector %0d flags", idx),
              int'(viol), int'(v.exp));
        check(int'(wr_count) == exp_count, $sformatf("R3 vector %0d count", idx),
              int'(wr_count), exp_count);
    endtask

    // Two back-to-back writes separated by gap samples of WE high.
    task automatic twin_write(input logic [15:0] a, input logic [15:0] d, input int gap);
        pulse_clr();
        ce_n = 1'b0; lb_n = 1'b0; ub_n = 1'b0; addr = a; data = d;
        repeat (5) step();
        we_n = 1'b0;
        repeat (4) step();
        we_n = 1'b1;
        repeat (gap) step();
        we_n = 1'b0;
        repeat (4) step();
        we_n = 1'b1;
        step();
        go_idle(9);
        exp_count += 2;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check(viol == 8'h00, "R13 flags after reset", int'(viol), 0);
        check(wr_count == 16'd0, "R13 count after reset", int'(wr_count), 0);

        for (int k = 0; k < 8; k++) begin
            run_vec(VECS[k], k);
        end

        // R1: one strobe rises while the other stays low: a single write.
        pulse_clr();
        ce_n = 1'b0; lb_n = 1'b0; ub_n = 1'b0; addr = 16'h0A00; data = 16'hBEEF;
        repeat (5) step();
        we_n = 1'b0;
        repeat (2) step();
        lb_n = 1'b1;
        repeat (3) step();
        we_n = 1'b1;
        step();
        go_idle(9);
        exp_count++;
        check(viol == 8'h00, "R1 strobe handover flags", int'(viol), 0);
        check(int'(wr_count) == exp_count, "R1 strobe handover single count",
              int'(wr_count), exp_count);

        // R9: spacing exactly at the limit is accepted.
        twin_write(16'h0B00, 16'h5A5A, 2);
        check(viol == 8'h00, "R9 spacing at limit", int'(viol), 0);
        check(int'(wr_count) == exp_count, "R3 twin count", int'(wr_count), exp_count);

        // R9: spacing one sample short is flagged.
        twin_write(16'h0C00, 16'hA5A5, 1);
        check(viol == 8'h20, "R9 spacing short", int'(viol), 32'h20);

        // R12: flag persists, then clears on clr.
        go_idle(5);
        check(viol == 8'h20, "R12 sticky flag", int'(viol), 32'h20);
        pulse_clr();
        step();
        check(viol == 8'h00, "R12 clear", int'(viol), 0);
        check(int'(wr_count) == exp_count, "R3 count unaffected by clear",
              int'(wr_count), exp_count);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule